// File: doc/BRIEF.md
# LCD Common Scan Timing Generator

This block turns a display-clock enable into the row-scan timing of a 65-row LCD frame: 64 ordinary common rows followed by one icon row. Each display-clock pulse advances a scan step. The block puts out the RAM row address for the current step and latches the 132-bit row that the display RAM returns. It then drives the common select for the row it has just latched, together with a latch strobe. A frame-alternation flag toggles once per frame, which gives two-frame alternating drive.

A programmable first row scrolls the picture vertically without touching RAM. The block captures it only at a frame boundary, so a frame is never split between two offsets. A direction control mirrors the common outputs, which also exchanges the lower and upper halves of the common bank. Blanking, inversion and all-pixels-on act only on the latched copy, after the latch. RAM contents and the readout sequence are never affected by them.

Readout is paced only by the display clock. The RAM port is a plain address/data pair: `ram_rdata` must show the row addressed by `ram_line` within the same clock cycle. There is no valid/ready handshake, because the scan cannot stall and no stage applies back-pressure. The segment output is a timed stream qualified by `latch_stb`.

Top module: `lcd_scan_timing`

## Requirements
- R1: A frame is 65 scan steps, numbered 0 to 64. Each `cl_tick` pulse moves to the next step, and step 64 is followed by step 0. Step 64 is the icon row.
- R2: `fr` inverts on the tick that leaves step 64 and on no other tick. Reset clears `fr` to 0.
- R3: During steps 0 to 63, `ram_line` equals (captured first row + step) mod 64. During step 64 it equals 64, the icon page address. The icon page can never come out of the offset.
- R4: `start_line` is sampled into the captured first row on the tick that leaves step 64. Values applied at any other time take effect only from the next frame. Reset sets the captured first row to 0.
- R5: On each tick the latch stores the `ram_rdata` presented for the current `ram_line`. `latch_stb` is high for exactly the one clock that follows the tick.
- R6: After a tick that latched step n < 64, `com_sel` has exactly one bit set: bit n when `com_reverse` was 0 at that tick, bit 63−n when it was 1. After a tick that latched step 64, `icon_sel` is 1 and `com_sel` is all zeros.
- R7: With the display on and `all_on` low, `inverse`=1 makes `seg_out` the bitwise complement of the latch, and `inverse`=0 makes it equal to the latch.
- R8: With the display on, `all_on`=1 drives every `seg_out` bit to 1 whatever `inverse` is.
- R9: With `disp_on`=0, `seg_out`, `com_sel` and `icon_sel` are all zero whatever the other modes are. Stepping, `fr` and RAM addressing continue unchanged.
- R10: After reset, before the first tick: `fr`=0, `ram_line`=0, `latch_stb`=0, and `seg_out`, `com_sel` and `icon_sel` are zero.
- R11: Changing `disp_on`, `inverse` or `all_on` between ticks never changes the latched row. Restoring the earlier modes brings back the earlier `seg_out` without a new tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl_tick | input | 1 | Display-clock enable, one pulse per scan step |
| start_line | input | 6 | First RAM row shown on common 0, applied from the next frame |
| com_reverse | input | 1 | 1 mirrors the common scan order |
| disp_on | input | 1 | 0 blanks segments and commons |
| inverse | input | 1 | 1 complements the latched pixels |
| all_on | input | 1 | 1 forces all segment pixels on |
| ram_rdata | input | 132 | RAM row for the current `ram_line` |
| ram_line | output | 7 | RAM row address of the current step (64 = icon page) |
| fr | output | 1 | Frame-alternation flag |
| latch_stb | output | 1 | One-clock pulse after each latch |
| seg_out | output | 132 | Mode-gated latched row |
| com_sel | output | 64 | One-hot physical common select |
| icon_sel | output | 1 | Icon common select |

## Verification
`ram_line` comes from registers through logic only, so it shows the new step in the clock after the tick edge, and the bench compares it in the cycle before the next tick. `fr`, `latch_stb`, `com_sel`, `icon_sel` and the latched row are all registered at the tick edge, so they are due one clock after the tick; `latch_stb` falls again one clock later. Mode inputs reach `seg_out` through gates only, so they act in the same cycle, and the bench checks them before the next tick. The bench drives on falling edges and samples each result at the first falling edge after the edge that produces it.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    SEG_BLANK  = 2'd0,
    SEG_FILL   = 2'd1,
    SEG_INVERT = 2'd2,
    SEG_PASS   = 2'd3
  } seg_mode_e;

  // Blanking wins over fill, fill wins over inversion.
  function automatic seg_mode_e seg_mode_pick(input logic on, input logic fill, input logic inv);
    if (!on)       return SEG_BLANK;
    else if (fill) return SEG_FILL;
    else if (inv)  return SEG_INVERT;
    else           return SEG_PASS;
  endfunction

endpackage

// File: rtl/lcd_scan_counter.sv
module lcd_scan_counter #(
  parameter int N_COM = 64,
  localparam int LW = $clog2(N_COM),
  localparam int SW = $clog2(N_COM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [LW-1:0] start_line,
  output logic [SW-1:0] step_o,
  output logic          fr_o,
  output logic [SW-1:0] ram_line_o
);
  localparam logic [SW-1:0] ICON  = SW'(N_COM);
  localparam logic [SW:0]   NWRAP = (SW+1)'(N_COM);

  logic [SW-1:0] step_q;
  logic          fr_q;
  logic [LW-1:0] cap_q;
  logic [SW:0]   sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      fr_q   <= 1'b0;
      cap_q  <= '0;
    end else if (tick) begin
      if (step_q == ICON) begin
        step_q <= '0;
        fr_q   <= ~fr_q;
        cap_q  <= start_line;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  always_comb begin
    sum = (SW+1)'(cap_q) + (SW+1)'(step_q);
    if (step_q == ICON)   ram_line_o = ICON;
    else if (sum >= NWRAP) ram_line_o = SW'(sum - NWRAP);
    else                  ram_line_o = SW'(sum);
  end

  assign step_o = step_q;
  assign fr_o   = fr_q;

  assert_step_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= ICON);

  assert_step_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && step_q == ICON) |=> (step_q == '0));

  assert_fr_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_q != $past(fr_q)) |-> ($past(tick) && $past(step_q) == ICON));

  assert_icon_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ICON) == (ram_line_o == ICON));

  assert_cap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q != $past(cap_q)) |-> ($past(tick) && $past(step_q) == ICON));

endmodule

// File: rtl/lcd_com_map.sv
module lcd_com_map #(
  parameter int N_COM = 64,
  localparam int SW = $clog2(N_COM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SW-1:0]    step,
  input  logic             reverse,
  input  logic             enable,
  output logic [N_COM-1:0] com_sel,
  output logic             icon_sel
);
  localparam logic [SW-1:0] ICON = SW'(N_COM);

  logic [SW-1:0]    lat_step;
  logic             lat_rev;
  logic             lat_valid;
  logic [N_COM-1:0] com_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_step  <= '0;
      lat_rev   <= 1'b0;
      lat_valid <= 1'b0;
    end else if (tick) begin
      lat_step  <= step;
      lat_rev   <= reverse;
      lat_valid <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_COM; g++) begin : g_com
    localparam logic [SW-1:0] FWD = SW'(g);
    localparam logic [SW-1:0] BWD = SW'(N_COM - 1 - g);
    assign com_raw[g] = lat_rev ? (lat_step == BWD) : (lat_step == FWD);
  end

  assign com_sel  = (enable && lat_valid) ? com_raw : '0;
  assign icon_sel = enable && lat_valid && (lat_step == ICON);

  assert_one_com_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({icon_sel, com_sel}));

  assert_icon_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    icon_sel |-> (com_sel == '0));

endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch
  import lcd_scan_pkg::*;
#(
  parameter int N_SEG = 132
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [N_SEG-1:0] ram_rdata,
  input  logic             disp_on,
  input  logic             inverse,
  input  logic             all_on,
  output logic [N_SEG-1:0] seg_out,
  output logic             latch_stb
);
  logic [N_SEG-1:0] latch_q;
  logic             stb_q;
  seg_mode_e        mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= tick;
      if (tick) latch_q <= ram_rdata;
    end
  end

  assign mode = seg_mode_pick(disp_on, all_on, inverse);

  always_comb begin
    unique case (mode)
      SEG_BLANK:  seg_out = '0;
      SEG_FILL:   seg_out = '1;
      SEG_INVERT: seg_out = ~latch_q;
      default:    seg_out = latch_q;
    endcase
  end

  assign latch_stb = stb_q;

  assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(latch_q));

  assert_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> $past(tick));

  assert_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on && all_on && inverse) |-> (seg_out == '1));

endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing #(
  parameter int N_COM = 64,
  parameter int N_SEG = 132,
  localparam int LW = $clog2(N_COM),
  localparam int SW = $clog2(N_COM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cl_tick,
  input  logic [LW-1:0]    start_line,
  input  logic             com_reverse,
  input  logic             disp_on,
  input  logic             inverse,
  input  logic             all_on,
  input  logic [N_SEG-1:0] ram_rdata,
  output logic [SW-1:0]    ram_line,
  output logic             fr,
  output logic             latch_stb,
  output logic [N_SEG-1:0] seg_out,
  output logic [N_COM-1:0] com_sel,
  output logic             icon_sel
);
  logic [SW-1:0] step;

  lcd_scan_counter #(.N_COM(N_COM)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (cl_tick),
    .start_line (start_line),
    .step_o     (step),
    .fr_o       (fr),
    .ram_line_o (ram_line)
  );

  lcd_com_map #(.N_COM(N_COM)) u_com (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (cl_tick),
    .step     (step),
    .reverse  (com_reverse),
    .enable   (disp_on),
    .com_sel  (com_sel),
    .icon_sel (icon_sel)
  );

  lcd_seg_latch #(.N_SEG(N_SEG)) u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (cl_tick),
    .ram_rdata (ram_rdata),
    .disp_on   (disp_on),
    .inverse   (inverse),
    .all_on    (all_on),
    .seg_out   (seg_out),
    .latch_stb (latch_stb)
  );

  assert_off_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (seg_out == '0 && com_sel == '0 && !icon_sel));

  assert_drive_after_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (com_sel != '0 || icon_sel) |-> disp_on);

endmodule

// File: tb/lcd_scan_timing_bench.sv
module lcd_scan_timing_bench;
  localparam int NC = 64;
  localparam int NS = 132;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cl_tick = 1'b0;
  logic [5:0]    start_line = '0;
  logic          com_reverse = 1'b0;
  logic          disp_on = 1'b0;
  logic          inverse = 1'b0;
  logic          all_on = 1'b0;
  logic [NS-1:0] ram_rdata;
  logic [6:0]    ram_line;
  logic          fr, latch_stb, icon_sel;
  logic [NS-1:0] seg_out;
  logic [NC-1:0] com_sel;

  logic [NS-1:0] mem [0:NC];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_step = 0;
  int m_cap = 0;
  bit m_fr = 1'b0;
  logic [NS-1:0] l_data = '0;

  always #4 clk = ~clk;

  assign ram_rdata = mem[ram_line];

  lcd_scan_timing u_lcd_scan_timing (
    .clk(clk), .rst_n(rst_n), .cl_tick(cl_tick), .start_line(start_line),
    .com_reverse(com_reverse), .disp_on(disp_on), .inverse(inverse), .all_on(all_on),
    .ram_rdata(ram_rdata), .ram_line(ram_line), .fr(fr), .latch_stb(latch_stb),
    .seg_out(seg_out), .com_sel(com_sel), .icon_sel(icon_sel)
  );

  task automatic check(input bit ok, input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] exp_seg(input logic [NS-1:0] d, input bit on, input bit fill, input bit inv);
    if (!on) return '0;
    if (fill) return '1;
    return inv ? ~d : d;
  endfunction

  function automatic logic [NC-1:0] exp_com(input int st, input bit rev, input bit on);
    logic [NC-1:0] r = '0;
    if (on && st < NC) r[rev ? NC-1-st : st] = 1'b1;
    return r;
  endfunction

  function automatic int exp_line(input int st, input int cap);
    return (st == NC) ? NC : (cap + st) % NC;
  endfunction

  // One scan step: check the address, pulse the tick, check the registered results.
  task automatic do_tick();
    int line, lst;
    bit lrev;
    line = exp_line(m_step, m_cap);
    check(ram_line == 7'(line), "R3 ram_line", NS'(ram_line), NS'(line));
    l_data = mem[line];
    lst = m_step;
    lrev = com_reverse;
    cl_tick = 1'b1;
    @(negedge clk);
    cl_tick = 1'b0;
    if (m_step == NC) begin
      m_step = 0;
      m_fr = ~m_fr;
      m_cap = int'(start_line);
    end else begin
      m_step++;
    end
    check(latch_stb == 1'b1, "R5 latch_stb high", NS'(latch_stb), NS'(1));
    check(fr == m_fr, "R2 fr", NS'(fr), NS'(m_fr));
    check(seg_out == exp_seg(l_data, disp_on, all_on, inverse), "R7/R8/R9 seg_out R5 latch",
          seg_out, exp_seg(l_data, disp_on, all_on, inverse));
    check(com_sel == exp_com(lst, lrev, disp_on), "R6 com_sel", NS'(com_sel), NS'(exp_com(lst, lrev, disp_on)));
    check(icon_sel == (disp_on && lst == NC), "R6 icon_sel", NS'(icon_sel), NS'(disp_on && lst == NC));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(latch_stb == 1'b0, "R5 latch_stb low", NS'(latch_stb), NS'(0));
    end
  endtask

  task automatic frame();
    for (int i = 0; i <= NC; i++) do_tick();
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i <= NC; i++)
      mem[i] = {$urandom(), $urandom(), $urandom(), $urandom(), 4'($urandom())};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(fr == 1'b0, "R10 fr", NS'(fr), NS'(0));
    check(ram_line == 7'd0, "R10 ram_line", NS'(ram_line), NS'(0));
    check(latch_stb == 1'b0, "R10 latch_stb", NS'(latch_stb), NS'(0));
    check(seg_out == '0, "R10 seg_out", seg_out, '0);
    check(com_sel == '0 && !icon_sel, "R10 com/icon", NS'({icon_sel, com_sel}), '0);

    // R1 R3 R4: frame 1 uses first row 0 even though start_line is set.
    disp_on = 1'b1;
    start_line = 6'd5;
    frame();
    check(m_cap == 5, "R4 capture", NS'(m_cap), NS'(5));
    // R6 reverse, R7 inverse, wrap of the offset
    com_reverse = 1'b1;
    inverse = 1'b1;
    start_line = 6'd63;
    frame();
    start_line = 6'd20;
    frame();

    // R11: mode changes between ticks leave the latch untouched
    inverse = 1'b0;
    do_tick();
    all_on = 1'b1;
    @(negedge clk);
    check(seg_out == '1, "R8 fill", seg_out, '1);
    disp_on = 1'b0;
    @(negedge clk);
    check(seg_out == '0 && com_sel == '0 && !icon_sel, "R9 blank", seg_out, '0);
    disp_on = 1'b1;
    all_on = 1'b0;
    @(negedge clk);
    check(seg_out == l_data, "R11 latch restored", seg_out, l_data);
    inverse = 1'b1;
    @(negedge clk);
    check(seg_out == ~l_data, "R11 inverse of held row R7", seg_out, ~l_data);

    // Random scan with random modes and gaps.
    for (int f = 0; f < 12; f++) begin
      for (int i = 0; i <= NC; i++) begin
        disp_on     = ($urandom_range(0, 9) != 0);
        inverse     = $urandom_range(0, 1);
        all_on      = ($urandom_range(0, 5) == 0);
        com_reverse = $urandom_range(0, 1);
        start_line  = 6'($urandom_range(0, 63));
        do_tick();
        idle($urandom_range(0, 3));
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule